// File: doc/BRIEF.md
# External Bus Write Controller

This block runs write cycles on a parallel external memory bus. A write is accepted from a small request port (start, address, data). It is then carried out in three timed phases: a lead phase, an active phase and a trail phase. Each phase lasts a programmable number of interface clock cycles. During the active phase the write strobes are low. The active phase is stretched for as long as the addressed device holds its ready line low.

The ready line can be treated as synchronous to the interface clock or as asynchronous. In asynchronous mode it passes through a two-stage synchronizer. The controller still samples it on the same clock edge as in synchronous mode, so the device-side level that is seen is the one from two cycles earlier. Between accesses, the address bus keeps the last address with bit 0 forced high. In the narrow (16-bit) data mode, the second write strobe pin carries address bit 0. All bus outputs come straight from registers.

Top module: `xbus_write_ctrl`

## Requirements
- R1: When `busy` is low and `req_start` is high at a clock edge, the access begins in the next cycle with `busy` high. A `req_start` seen while `busy` is high is ignored.
- R2: For every cycle of an access, `bus_cs_n` and `bus_rnw` are low and `bus_addr` equals the accepted address. Outside an access both are high.
- R3: The lead phase lasts max(`cfg_lead`,1) cycles with `bus_we0_n` high. The active phase lasts at least max(`cfg_active`,1) cycles with `bus_we0_n` low. The trail phase lasts `cfg_trail` cycles (0 allowed) with `bus_we0_n` high.
- R4: With `cfg_async`=0, `rdy_in` is sampled at the clock edge that ends the minimum active phase, that is lead+active cycles after the access starts. A low sample adds one active cycle and the line is sampled again at the next edge.
- R5: With `cfg_async`=1, the sample taken at that same edge is the `rdy_in` level from two edges earlier. This is the same as moving the first sampling point two cycles earlier.
- R6: While idle, `bus_addr` holds the last accepted address with bit 0 forced to 1. After reset it reads 1.
- R7: With `cfg_wide`=1, `bus_we1_n` follows `bus_we0_n`. With `cfg_wide`=0, `bus_we1_n` carries address bit 0 during an access and is 1 while idle.
- R8: `bus_doe` is high during the active and trail phases only. While it is high, `bus_dout` equals the accepted data. It drops in the same cycle that `bus_rnw` returns high.
- R9: `done` is high for exactly one cycle, the first idle cycle after an access.
- R10: The phase counts and the two mode inputs are captured at acceptance. Changing them during an access has no effect on that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Request a write (taken when idle) |
| req_addr | input | ADDR_W | Write address |
| req_data | input | DATA_W | Write data |
| cfg_lead | input | CNT_W | Lead phase cycles (0 acts as 1) |
| cfg_active | input | CNT_W | Minimum active phase cycles (0 acts as 1) |
| cfg_trail | input | CNT_W | Trail phase cycles |
| cfg_async | input | 1 | 1: ready is asynchronous and is synchronized first |
| cfg_wide | input | 1 | 1: 32-bit data mode, 0: 16-bit mode |
| rdy_in | input | 1 | Ready from the external device |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle pulse after an access ends |
| bus_cs_n | output | 1 | Zone chip select, active low |
| bus_we0_n | output | 1 | Lower write strobe, active low |
| bus_we1_n | output | 1 | Upper write strobe, or address bit 0 in 16-bit mode |
| bus_rnw | output | 1 | Read/write line, low for a write |
| bus_addr | output | ADDR_W | External address bus |
| bus_dout | output | DATA_W | Data to drive onto the bus |
| bus_doe | output | 1 | Data bus drive enable |

## Verification
The hardest case to reach is asynchronous ready on an access whose lead plus active count is only two cycles. There the first sample already looks at a level from before the access started, so the access ends even if the device drops ready just after acceptance. The stimulus builds this case by dropping `rdy_in` in the first access cycle with minimal counts. It also holds ready low across several sampling edges in both modes, and during an access it changes the configuration and fires a second request. The length of every access is checked against a closed-form count derived from the ready pattern.

// File: rtl/ewc_pkg.sv
package ewc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_LEAD   = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_TRAIL  = 2'd3
  } ewc_phase_e;
endpackage

// File: rtl/ewc_rdy_sync.sv
module ewc_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rdy_in,
  input  logic use_sync,
  output logic rdy_smp
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= rdy_in;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], rdy_in};
      end
    end
  endgenerate

  assign rdy_smp = use_sync ? chain_q[STAGES-1] : rdy_in;
endmodule

// File: rtl/ewc_phase_fsm.sv
module ewc_phase_fsm
  import ewc_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] cfg_lead,
  input  logic [CNT_W-1:0] cfg_active,
  input  logic [CNT_W-1:0] cfg_trail,
  input  logic             rdy_smp,
  output ewc_phase_e       phase_nxt,
  output logic             accept,
  output logic             busy,
  output logic             done
);
  ewc_phase_e       ph_q, ph_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] act_m1_q, trail_q;
  logic [CNT_W-1:0] lead_m1, act_m1;

  assign lead_m1 = (cfg_lead == '0)   ? '0 : cfg_lead - 1'b1;
  assign act_m1  = (cfg_active == '0) ? '0 : cfg_active - 1'b1;

  always_comb begin
    ph_n   = ph_q;
    cnt_n  = cnt_q;
    accept = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (start) begin
          accept = 1'b1;
          ph_n   = PH_LEAD;
          cnt_n  = lead_m1;
        end
      end
      PH_LEAD: begin
        if (cnt_q == '0) begin
          ph_n  = PH_ACTIVE;
          cnt_n = act_m1_q;
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
      PH_ACTIVE: begin
        if (cnt_q != '0) begin
          cnt_n = cnt_q - 1'b1;
        end else if (rdy_smp) begin
          if (trail_q == '0) begin
            ph_n = PH_IDLE;
          end else begin
            ph_n  = PH_TRAIL;
            cnt_n = trail_q - 1'b1;
          end
        end
      end
      PH_TRAIL: begin
        if (cnt_q == '0) ph_n = PH_IDLE;
        else             cnt_n = cnt_q - 1'b1;
      end
      default: ph_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q     <= PH_IDLE;
      cnt_q    <= '0;
      act_m1_q <= '0;
      trail_q  <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      ph_q  <= ph_n;
      cnt_q <= cnt_n;
      if (accept) begin
        act_m1_q <= act_m1;
        trail_q  <= cfg_trail;
      end
      busy <= (ph_n != PH_IDLE);
      done <= (ph_q != PH_IDLE) && (ph_n == PH_IDLE);
    end
  end

  assign phase_nxt = ph_n;
endmodule

// File: rtl/ewc_pin_drive.sv
module ewc_pin_drive
  import ewc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  ewc_phase_e        phase_nxt,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              ld_wide,
  output logic              cs_n,
  output logic              we0_n,
  output logic              we1_n,
  output logic              rnw,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dout,
  output logic              doe
);
  logic [ADDR_W-1:0] addr_q, a_cur;
  logic              wide_q, w_cur;
  logic              cs_n_d, we0_n_d, we1_n_d, rnw_d, doe_d;
  logic [ADDR_W-1:0] addr_d;

  assign a_cur = load ? ld_addr : addr_q;
  assign w_cur = load ? ld_wide : wide_q;

  always_comb begin
    cs_n_d  = 1'b0;
    rnw_d   = 1'b0;
    we0_n_d = 1'b1;
    we1_n_d = w_cur ? 1'b1 : a_cur[0];
    addr_d  = a_cur;
    doe_d   = 1'b0;
    unique case (phase_nxt)
      PH_IDLE: begin
        cs_n_d  = 1'b1;
        rnw_d   = 1'b1;
        we1_n_d = 1'b1;
        addr_d  = {a_cur[ADDR_W-1:1], 1'b1};
      end
      PH_LEAD: begin
      end
      PH_ACTIVE: begin
        we0_n_d = 1'b0;
        we1_n_d = w_cur ? 1'b0 : a_cur[0];
        doe_d   = 1'b1;
      end
      PH_TRAIL: begin
        doe_d = 1'b1;
      end
      default: begin
        cs_n_d = 1'b1;
        rnw_d  = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      wide_q <= 1'b1;
      dout   <= '0;
      cs_n   <= 1'b1;
      we0_n  <= 1'b1;
      we1_n  <= 1'b1;
      rnw    <= 1'b1;
      addr   <= {{(ADDR_W-1){1'b0}}, 1'b1};
      doe    <= 1'b0;
    end else begin
      if (load) begin
        addr_q <= ld_addr;
        wide_q <= ld_wide;
        dout   <= ld_data;
      end
      cs_n  <= cs_n_d;
      we0_n <= we0_n_d;
      we1_n <= we1_n_d;
      rnw   <= rnw_d;
      addr  <= addr_d;
      doe   <= doe_d;
    end
  end
endmodule

// File: rtl/xbus_write_ctrl.sv
module xbus_write_ctrl
  import ewc_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_start,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [CNT_W-1:0]  cfg_lead,
  input  logic [CNT_W-1:0]  cfg_active,
  input  logic [CNT_W-1:0]  cfg_trail,
  input  logic              cfg_async,
  input  logic              cfg_wide,
  input  logic              rdy_in,
  output logic              busy,
  output logic              done,
  output logic              bus_cs_n,
  output logic              bus_we0_n,
  output logic              bus_we1_n,
  output logic              bus_rnw,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe
);
  ewc_phase_e phase_nxt;
  logic       accept;
  logic       async_q;
  logic       rdy_smp;

  always_ff @(posedge clk) begin
    if (rst)         async_q <= 1'b0;
    else if (accept) async_q <= cfg_async;
  end

  ewc_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .rdy_in   (rdy_in),
    .use_sync (async_q),
    .rdy_smp  (rdy_smp)
  );

  ewc_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .start      (req_start),
    .cfg_lead   (cfg_lead),
    .cfg_active (cfg_active),
    .cfg_trail  (cfg_trail),
    .rdy_smp    (rdy_smp),
    .phase_nxt  (phase_nxt),
    .accept     (accept),
    .busy       (busy),
    .done       (done)
  );

  ewc_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk       (clk),
    .rst       (rst),
    .phase_nxt (phase_nxt),
    .load      (accept),
    .ld_addr   (req_addr),
    .ld_data   (req_data),
    .ld_wide   (cfg_wide),
    .cs_n      (bus_cs_n),
    .we0_n     (bus_we0_n),
    .we1_n     (bus_we1_n),
    .rnw       (bus_rnw),
    .addr      (bus_addr),
    .dout      (bus_dout),
    .doe       (bus_doe)
  );
endmodule

// File: rtl/xbus_write_ctrl_chk.sv
module xbus_write_ctrl_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_start,
  input logic              busy,
  input logic              done,
  input logic              bus_cs_n,
  input logic              bus_we0_n,
  input logic              bus_rnw,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_doe
);
  assert_accept_R1: assert property (@(posedge clk) disable iff (rst)
    (!busy && req_start) |=> busy);

  assert_cs_in_access_R2: assert property (@(posedge clk) disable iff (rst)
    busy |-> (!bus_cs_n && !bus_rnw));

  assert_cs_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (bus_cs_n && bus_rnw));

  assert_addr_steady_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(bus_addr));

  assert_strobe_in_cs_R3: assert property (@(posedge clk) disable iff (rst)
    !bus_we0_n |-> !bus_cs_n);

  assert_idle_a0_R6: assert property (@(posedge clk) disable iff (rst)
    !busy |-> bus_addr[0]);

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy)) |-> $stable(bus_addr));

  assert_doe_write_R8: assert property (@(posedge clk) disable iff (rst)
    bus_doe |-> !bus_rnw);

  assert_strobe_doe_R8: assert property (@(posedge clk) disable iff (rst)
    !bus_we0_n |-> bus_doe);

  assert_done_after_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind xbus_write_ctrl xbus_write_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_start (req_start),
  .busy      (busy),
  .done      (done),
  .bus_cs_n  (bus_cs_n),
  .bus_we0_n (bus_we0_n),
  .bus_rnw   (bus_rnw),
  .bus_addr  (bus_addr),
  .bus_doe   (bus_doe)
);

// File: tb/xbus_write_ctrl_test.sv
`timescale 1ns/1ps
module xbus_write_ctrl_test;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_start = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic [CW-1:0] cfg_lead = '0, cfg_active = '0, cfg_trail = '0;
  logic          cfg_async = 1'b0, cfg_wide = 1'b1;
  logic          rdy_in = 1'b1;
  logic          busy, done, bus_cs_n, bus_we0_n, bus_we1_n, bus_rnw, bus_doe;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_dout;

  always #2.5 clk = ~clk;

  xbus_write_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .req_start(req_start), .req_addr(req_addr),
    .req_data(req_data), .cfg_lead(cfg_lead), .cfg_active(cfg_active),
    .cfg_trail(cfg_trail), .cfg_async(cfg_async), .cfg_wide(cfg_wide),
    .rdy_in(rdy_in), .busy(busy), .done(done), .bus_cs_n(bus_cs_n),
    .bus_we0_n(bus_we0_n), .bus_we1_n(bus_we1_n), .bus_rnw(bus_rnw),
    .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_doe(bus_doe)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  task automatic chk(input string rq, input string nm,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, nm, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Reference model: time-indexed view of one access
  int            m_busy = 0, m_t = 0, m_lp = 1, m_ap = 1, m_tp = 0;
  int            m_async = 0, m_wide = 1, m_actend = -1, m_done = 0;
  int            p1 = 0, p2 = 0, rsel = 0;
  logic [AW-1:0] m_addr = '0, m_last = '0;
  logic [DW-1:0] m_data = '0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
      report();
    end
    if (rst) begin
      m_busy = 0; m_done = 0; p1 = 0; p2 = 0; m_last = '0;
    end else begin
      rsel   = (m_async != 0) ? p2 : int'(rdy_in);
      m_done = 0;
      if (m_busy == 0) begin
        if (req_start) begin
          m_busy   = 1;
          m_t      = 0;
          m_lp     = (cfg_lead == 0) ? 1 : int'(cfg_lead);
          m_ap     = (cfg_active == 0) ? 1 : int'(cfg_active);
          m_tp     = int'(cfg_trail);
          m_async  = int'(cfg_async);
          m_wide   = int'(cfg_wide);
          m_addr   = req_addr;
          m_data   = req_data;
          m_actend = -1;
        end
      end else begin
        if (m_actend < 0 && m_t >= m_lp + m_ap - 1 && rsel != 0) m_actend = m_t;
        if (m_actend >= 0 && m_t + 1 > m_actend + m_tp) begin
          m_busy = 0; m_done = 1; m_last = m_addr;
        end else begin
          m_t++;
        end
      end
      p2 = p1;
      p1 = int'(rdy_in);
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      logic e_lead, e_act, e_we0, e_we1;
      e_lead = (m_busy != 0) && (m_t < m_lp);
      e_act  = (m_busy != 0) && !e_lead && (m_actend < 0 || m_t <= m_actend);
      e_we0  = !e_act;
      e_we1  = (m_busy == 0) ? 1'b1 : ((m_wide != 0) ? e_we0 : m_addr[0]);
      chk("R1", "busy", busy, (m_busy != 0));
      chk("R9", "done", done, (m_done != 0));
      chk("R2", "cs_n", bus_cs_n, (m_busy == 0));
      chk("R2", "rnw", bus_rnw, (m_busy == 0));
      if (m_busy != 0) chk("R2", "addr", bus_addr, m_addr);
      else             chk("R6", "idle addr", bus_addr, {m_last[AW-1:1], 1'b1});
      chk("R3", "we0_n", bus_we0_n, e_we0);
      chk("R7", "we1_n", bus_we1_n, e_we1);
      chk("R8", "doe", bus_doe, (m_busy != 0) && !e_lead);
      if (bus_doe) chk("R8", "dout", bus_dout, m_data);
    end
  end

  function automatic int exp_len(int l, int a, int t, int as, int low);
    int lp, ap, first, ae;
    lp    = (l == 0) ? 1 : l;
    ap    = (a == 0) ? 1 : a;
    first = lp + ap - 1;
    if (as == 0)                   ae = (low > first) ? low : first;
    else if (low == 0 || first < 2) ae = first;
    else                            ae = (low + 2 > first) ? low + 2 : first;
    return ae + 1 + t;
  endfunction

  task automatic do_wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input int l, input int act, input int t,
                       input int as, input int wd, input int low,
                       input int poke, input string rq);
    int c;
    @(negedge clk);
    cfg_lead = CW'(l); cfg_active = CW'(act); cfg_trail = CW'(t);
    cfg_async = as[0]; cfg_wide = wd[0];
    req_addr = a; req_data = d; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    c = 0;
    while (busy === 1'b1 && c < 1000) begin
      rdy_in = (c >= low);
      if (poke != 0 && c == 1) begin
        req_start = 1'b1; req_addr = ~a; req_data = ~d;
        cfg_lead = CW'(l + 3); cfg_active = CW'(act + 2); cfg_trail = CW'(t + 1);
        cfg_async = ~as[0]; cfg_wide = ~wd[0];
      end
      c++;
      @(negedge clk);
    end
    req_start = 1'b0;
    rdy_in = 1'b1;
    chk(rq, "access length", c, exp_len(l, act, t, as, low));
    chk("R9", "done at end", done, 1'b1);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9", "reset busy", busy, 1'b0);
    chk("R2", "reset cs_n", bus_cs_n, 1'b1);
    chk("R6", "reset addr", bus_addr, 16'h0001);
    chk("R8", "reset doe", bus_doe, 1'b0);
    repeat (3) @(negedge clk);
    // R4: synchronous ready, ready high at first sample
    do_wr(16'h1234, 32'hA5A5_0001, 2, 3, 2, 0, 1, 0, 0, "R4");
    // R4: synchronous ready held low past the first sample
    do_wr(16'h0F0F, 32'h1111_2222, 1, 2, 1, 0, 1, 6, 0, "R4");
    // R5: asynchronous ready, high throughout
    do_wr(16'h2222, 32'h3333_4444, 3, 1, 0, 1, 1, 0, 0, "R5");
    // R5: asynchronous ready low, end moves two cycles later
    do_wr(16'h3333, 32'h5555_6666, 1, 3, 2, 1, 1, 5, 0, "R5");
    // R3: zero counts act as one lead and one active cycle, no trail
    do_wr(16'h0000, 32'h7777_8888, 0, 0, 0, 0, 1, 0, 0, "R3");
    // R5: short access sees ready from before the drop
    do_wr(16'h0100, 32'h9999_AAAA, 1, 1, 1, 1, 1, 4, 0, "R5");
    // R7: narrow mode, odd and even address
    do_wr(16'h4445, 32'hBBBB_CCCC, 1, 2, 1, 0, 0, 0, 0, "R7");
    do_wr(16'h4446, 32'hDDDD_EEEE, 2, 2, 2, 0, 0, 2, 0, "R7");
    // R10 and R1: config changes and a new request during the access
    do_wr(16'h5A5A, 32'h0123_4567, 2, 2, 3, 0, 1, 3, 1, "R10");
    do_wr(16'h6B6B, 32'h89AB_CDEF, 1, 3, 1, 1, 0, 2, 1, "R10");
    // R3: largest counts
    do_wr(16'hFFFE, 32'hFEDC_BA98, 15, 15, 15, 0, 1, 0, 0, "R3");
    report();
  end
endmodule